// File: doc/BRIEF.md
# Address Tenure Watchdog

This block watches every address phase on a shared system bus. A master's transfer-start pulse opens a tenure. The block then counts clock cycles until a slave returns the address acknowledge. If no slave answers before a programmable limit, the watchdog closes the address phase itself by pulsing an acknowledge of its own. It then flags a transfer error on the first cycle of the data phase that belongs to the failed transfer. This lets a bus hung on an absent or broken slave recover without a reset.

On every expiry the block also sets a sticky time-out flag that software clears by writing a one. An interrupt line follows that flag while the interrupt enable is high. The limit lives in a 12-bit register held in the block. It comes out of reset at its largest value, and a write strobe replaces it. All pins are plain control and status levels or pulses. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `addr_tenure_wdt`

## Requirements
- R1: While reset is low and right after it, `aack_o`, `tea_o`, `status_o` and `irq_o` are 0 and `limit_o` reads 4095 (all twelve bits set).
- R2: If `ts_i` is sampled high in cycle c with the watchdog enabled and idle, and `aack_i` stays low, `aack_o` is high for exactly one cycle, in cycle c+L+2, where L is `limit_o` at that time.
- R3: An `aack_i` sampled while a tenure is pending ends it with no `aack_o`. The next tenure again gets the full L+2 cycle window.
- R4: After a generated acknowledge, `tea_o` is high for exactly one cycle: the first cycle in which `dstart_i` is high. It is never high at any other time.
- R5: `status_o` becomes 1 in the same cycle as the generated `aack_o` and stays 1 until cleared.
- R6: A `stat_clr_i` pulse clears `status_o` in the next cycle. If an expiry happens in the same cycle as the clear, the status stays set.
- R7: `irq_o` is high exactly while both `status_o` and `irq_en_i` are high.
- R8: While `wd_en_i` is low, a `ts_i` starts no tenure. Dropping `wd_en_i` during a pending tenure abandons it, so no `aack_o` or status follows.
- R9: A `ts_i` that arrives while a tenure is pending, or while a data-phase error is awaited, is ignored. The original expiry time stands.
- R10: A `limit_we_i` pulse loads `limit_wd_i` into the limit, which is visible on `limit_o` in the next cycle.
- R11: An `aack_i` in the cycle the count reaches the limit beats the expiry: no `aack_o` and no status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ts_i | input | 1 | Transfer start from the bus master |
| aack_i | input | 1 | Address acknowledge from the slaves |
| dstart_i | input | 1 | Marks the first cycle of a data tenure |
| wd_en_i | input | 1 | Watchdog enable |
| irq_en_i | input | 1 | Interrupt enable for the time-out flag |
| limit_we_i | input | 1 | Limit register write strobe |
| limit_wd_i | input | 12 | Limit register write data |
| stat_clr_i | input | 1 | Write-one-to-clear strobe for the time-out flag |
| aack_o | output | 1 | Generated address acknowledge |
| tea_o | output | 1 | Generated transfer error for the data tenure |
| limit_o | output | 12 | Current limit value |
| status_o | output | 1 | Sticky address time-out flag |
| irq_o | output | 1 | Interrupt request |

## Verification
A counter that is off by one moves the generated acknowledge one cycle away from c+L+2. A counter that is not cleared between tenures shortens the next window. Both show on `aack_o` the cycle they happen. A sequencer stuck in the wrong state shows as a missing or misplaced `tea_o`, which is visible on the first data-start pulse after expiry. A wrong status flag shows on `status_o` and `irq_o` in the same cycle. The bench compares every output against its reference model on every cycle, so any such fault is reported in the cycle it first reaches a port.

// File: rtl/atw_pkg.sv
package atw_pkg;
  localparam int unsigned LIMIT_W = 12;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PEND  = 2'd1,
    ST_DWAIT = 2'd2
  } atw_state_e;
endpackage

// File: rtl/atw_count.sv
module atw_count #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == limit);
endmodule

// File: rtl/atw_seq.sv
module atw_seq
  import atw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ts,
  input  logic aack_in,
  input  logic dstart,
  input  logic hit,
  output logic cnt_clr,
  output logic cnt_run,
  output logic fire,
  output logic aack_gen,
  output logic tea_gen
);
  atw_state_e st_q, st_d;
  logic       aack_q;

  always_comb begin
    st_d    = st_q;
    cnt_clr = 1'b0;
    cnt_run = 1'b0;
    fire    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (en && ts && !aack_in) begin
          st_d    = ST_PEND;
          cnt_clr = 1'b1;
        end
      end
      ST_PEND: begin
        if (!en || aack_in) begin
          st_d = ST_IDLE;
        end else if (hit) begin
          st_d = ST_DWAIT;
          fire = 1'b1;
        end else begin
          cnt_run = 1'b1;
        end
      end
      ST_DWAIT: begin
        if (dstart) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      aack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      aack_q <= fire;
    end
  end

  assign aack_gen = aack_q;
  assign tea_gen  = (st_q == ST_DWAIT) && dstart;
endmodule

// File: rtl/atw_regs.sv
module atw_regs #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lim_we,
  input  logic [W-1:0] lim_wd,
  input  logic         set,
  input  logic         clr,
  input  logic         irq_en,
  output logic [W-1:0] limit,
  output logic         flag,
  output logic         irq
);
  localparam logic [W-1:0] LIM_RST = '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit <= LIM_RST;
      flag  <= 1'b0;
    end else begin
      if (lim_we) limit <= lim_wd;
      if (set)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  assign irq = flag && irq_en;
endmodule

// File: rtl/addr_tenure_wdt.sv
module addr_tenure_wdt
  import atw_pkg::*;
#(
  parameter int unsigned LW = LIMIT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ts_i,
  input  logic          aack_i,
  input  logic          dstart_i,
  input  logic          wd_en_i,
  input  logic          irq_en_i,
  input  logic          limit_we_i,
  input  logic [LW-1:0] limit_wd_i,
  input  logic          stat_clr_i,
  output logic          aack_o,
  output logic          tea_o,
  output logic [LW-1:0] limit_o,
  output logic          status_o,
  output logic          irq_o
);
  logic cnt_clr, cnt_run, hit, fire;

  atw_count #(.W(LW)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .run(cnt_run),
    .limit(limit_o), .hit(hit)
  );

  atw_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(wd_en_i), .ts(ts_i), .aack_in(aack_i),
    .dstart(dstart_i), .hit(hit), .cnt_clr(cnt_clr), .cnt_run(cnt_run),
    .fire(fire), .aack_gen(aack_o), .tea_gen(tea_o)
  );

  atw_regs #(.W(LW)) u_regs (
    .clk(clk), .rst_n(rst_n), .lim_we(limit_we_i), .lim_wd(limit_wd_i),
    .set(fire), .clr(stat_clr_i), .irq_en(irq_en_i),
    .limit(limit_o), .flag(status_o), .irq(irq_o)
  );
endmodule

// File: rtl/atw_chk.sv
module atw_chk (
  input logic clk,
  input logic rst_n,
  input logic aack_i,
  input logic dstart_i,
  input logic stat_clr_i,
  input logic irq_en_i,
  input logic aack_o,
  input logic tea_o,
  input logic status_o,
  input logic irq_o
);
  // R2
  aack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aack_o |=> !aack_o);
  // R3
  aack_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aack_i |=> !aack_o);
  // R4
  tea_on_dstart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tea_o |-> dstart_i);
  // R4
  tea_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tea_o |=> !tea_o);
  // R5
  flag_with_aack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aack_o |-> status_o);
  // R6
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_clr_i |=> (!status_o || aack_o));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_en_i && status_o));
endmodule

bind addr_tenure_wdt atw_chk u_atw_chk (
  .clk(clk), .rst_n(rst_n), .aack_i(aack_i), .dstart_i(dstart_i),
  .stat_clr_i(stat_clr_i), .irq_en_i(irq_en_i), .aack_o(aack_o),
  .tea_o(tea_o), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/test_addr_tenure_wdt.sv
module test_addr_tenure_wdt;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ts_i = 0, aack_i = 0, dstart_i = 0, wd_en_i = 1, irq_en_i = 0;
  logic limit_we_i = 0, stat_clr_i = 0;
  logic [11:0] limit_wd_i = '0;
  logic aack_o, tea_o, status_o, irq_o;
  logic [11:0] limit_o;

  int checks = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  int  m_phase = 0;      // 0 idle, 1 waiting for acknowledge, 2 waiting for data start
  int  m_elapsed = 0;
  int  m_lim = 4095;
  bit  m_aack = 0, m_flag = 0;

  always #2 clk = ~clk;

  addr_tenure_wdt i_addr_tenure_wdt (
    .clk(clk), .rst_n(rst_n), .ts_i(ts_i), .aack_i(aack_i), .dstart_i(dstart_i),
    .wd_en_i(wd_en_i), .irq_en_i(irq_en_i), .limit_we_i(limit_we_i),
    .limit_wd_i(limit_wd_i), .stat_clr_i(stat_clr_i), .aack_o(aack_o),
    .tea_o(tea_o), .limit_o(limit_o), .status_o(status_o), .irq_o(irq_o)
  );

  always @(posedge clk) begin
    bit expire;
    expire = 0;
    if (!rst_n) begin
      m_phase = 0; m_elapsed = 0; m_lim = 4095; m_aack = 0; m_flag = 0;
    end else begin
      if (m_phase == 0) begin
        if (wd_en_i && ts_i && !aack_i) begin m_phase = 1; m_elapsed = 0; end
      end else if (m_phase == 1) begin
        if (!wd_en_i || aack_i) m_phase = 0;
        else if (m_elapsed >= m_lim) begin m_phase = 2; expire = 1; end
        else m_elapsed++;
      end else if (dstart_i) begin
        m_phase = 0;
      end
      m_aack = expire;
      if (expire) m_flag = 1;
      else if (stat_clr_i) m_flag = 0;
      if (limit_we_i) m_lim = int'(limit_wd_i);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual %0d cycles expected < 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", cur_req, what, $time, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      #1;
      chk("aack_o", aack_o, m_aack);
      chk("tea_o", tea_o, (m_phase == 2) && dstart_i);
      chk("status_o", status_o, m_flag);
      chk("irq_o", irq_o, m_flag && irq_en_i);
      chk("limit_o", limit_o, m_lim);
      @(negedge clk);
    end
  endtask

  task automatic pulse_ts();
    ts_i = 1; tick(1); ts_i = 0;
  endtask

  task automatic set_limit(int v);
    limit_we_i = 1; limit_wd_i = 12'(v); tick(1); limit_we_i = 0;
  endtask

  task automatic clear_flag();
    stat_clr_i = 1; tick(1); stat_clr_i = 0;
  endtask

  initial begin
    @(negedge clk);
    cur_req = "R1"; tick(3);
    rst_n = 1; tick(2);

    cur_req = "R10"; set_limit(5); tick(2);

    // expiry then data start, interrupt enabled
    cur_req = "R2"; irq_en_i = 1; pulse_ts(); tick(10);
    cur_req = "R4"; dstart_i = 1; tick(1); dstart_i = 0; tick(2);
    dstart_i = 1; tick(1); dstart_i = 0; tick(1);
    cur_req = "R7"; irq_en_i = 0; tick(2); irq_en_i = 1; tick(2);
    cur_req = "R6"; clear_flag(); tick(2);

    // acknowledge before expiry, then a full window again
    cur_req = "R3"; pulse_ts(); tick(2); aack_i = 1; tick(1); aack_i = 0; tick(3);
    pulse_ts(); tick(9); dstart_i = 1; tick(1); dstart_i = 0; tick(1);

    // clear in the expiry cycle: set wins
    cur_req = "R6"; clear_flag(); tick(1); pulse_ts(); tick(5);
    stat_clr_i = 1; tick(1); stat_clr_i = 0; tick(3);
    dstart_i = 1; tick(1); dstart_i = 0; clear_flag(); tick(2);

    // acknowledge exactly at the limit beats the expiry
    cur_req = "R11"; pulse_ts(); tick(5); aack_i = 1; tick(1); aack_i = 0; tick(4);

    // disabled watchdog
    cur_req = "R8"; wd_en_i = 0; pulse_ts(); tick(10); wd_en_i = 1; tick(1);
    pulse_ts(); tick(3); wd_en_i = 0; tick(1); wd_en_i = 1; tick(8);

    // repeated transfer start while busy
    cur_req = "R9"; pulse_ts(); tick(3); pulse_ts(); tick(3);
    pulse_ts(); tick(3); pulse_ts(); dstart_i = 1; tick(1); dstart_i = 0; tick(4);
    clear_flag(); tick(1);

    // limit of zero
    cur_req = "R10"; set_limit(0); cur_req = "R2"; pulse_ts(); tick(3);
    dstart_i = 1; tick(1); dstart_i = 0; clear_flag(); tick(1);

    // default limit after a fresh reset
    cur_req = "R1"; rst_n = 0; tick(2); rst_n = 1; tick(1);
    cur_req = "R2"; pulse_ts(); tick(4100); dstart_i = 1; tick(1); dstart_i = 0; tick(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule